// File: doc/BRIEF.md
# Word-Level Max-Prefix Network

This block takes a vector of N signed words and returns, at every index, the largest word found at that index or any lower index. Each node of the network is a whole-word maximum operator, not a single-bit carry cell. The most negative code of the word width stands for minus infinity. It is the identity of the operator, so a word holding it never raises a prefix.

The nodes follow a sparse Brent-Kung schedule. An up-sweep builds maxima over spans of growing power-of-two width. A down-sweep then fills in the indices the tree skipped. Every node is placed at the earliest level where both of its operands are ready, so the network uses 2·log2(N) − 2 levels for N ≥ 4. An optional register stage after every level makes the network a fully pipelined unit. It accepts one vector per cycle and carries the valid flag alongside the data.

Top module: `maxpfx_bk`

## Requirements
- R1: When out_valid is high, output word i (bits i·W+W−1 down to i·W of out_data) equals the signed maximum of input words 0 through i of the corresponding input vector.
- R2: The code with only the sign bit set acts as minus infinity. An all-minus-infinity input yields an all-minus-infinity output, and a minus-infinity word never changes any prefix.
- R3: Output word 0 equals input word 0 unchanged.
- R4: Output words never decrease from index i−1 to index i, compared as signed values.
- R5: With PIPE=1, out_valid and the result for a vector presented with in_valid high appear exactly LAT = 2·log2(N) − 2 clock cycles after the cycle in which that vector was presented. With PIPE=0 they appear in the same cycle. Each presented vector produces exactly one valid output.
- R6: With PIPE=1, vectors may be presented on consecutive cycles, and each result leaves in order, one per cycle.
- R7: With PIPE=1, out_data keeps its last value during every cycle in which out_valid is low.
- R8: While rst is high at a clock edge, the outputs return to out_valid low and every out_data word set to minus infinity.
- R9: Words are compared as two's-complement values, so the largest positive code (0x7FFF for W=16) wins over all negative words without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks in_data as a vector to process |
| in_data | input | N*W | N signed words, word i in bits i*W+W-1 : i*W |
| out_valid | output | 1 | Marks out_data as a finished prefix vector |
| out_data | output | N*W | N prefix maxima, same packing as in_data |

## Verification
With the default N=16 and PIPE=1, each result is due 6 cycles after its vector is driven. The driver stamps every expected vector with the cycle count at which it must appear. The monitor samples 1 ns after each rising edge and requires the head of its queue to match both in data and in due cycle. A valid output with nothing due, or a due item with out_valid low, counts as a latency failure. Every idle cycle after the first result also compares out_data with the last delivered vector, which covers the hold behaviour.

// File: rtl/maxpfx_pkg.sv
package maxpfx_pkg;

    localparam int MAX_N = 256;

    // Walks the Brent-Kung operator list in dependency order and places each
    // operator at the earliest level where both operands are final.
    // want_depth=1 returns the level count; otherwise returns the partner
    // index of the operator writing position pos at level lvl, or -1.
    function automatic int bk_walk(input int n, input int lvl, input int pos,
                                   input bit want_depth);
        int rdy [MAX_N];
        int lg;
        int res;
        int depth;
        int j;
        int t;
        for (int i = 0; i < MAX_N; i++) rdy[i] = 0;
        lg    = $clog2(n);
        res   = -1;
        depth = 0;
        for (int d = 0; d < lg; d++) begin
            for (int i = 0; i < n; i++) begin
                if (((i + 1) % (1 << (d + 1))) == 0) begin
                    j = i - (1 << d);
                    t = ((rdy[i] > rdy[j]) ? rdy[i] : rdy[j]) + 1;
                    rdy[i] = t;
                    if (t > depth) depth = t;
                    if (t == lvl && i == pos) res = j;
                end
            end
        end
        for (int d = lg - 2; d >= 0; d--) begin
            for (int i = 0; i < n; i++) begin
                if (i >= (1 << (d + 1)) && ((i + 1) % (1 << (d + 1))) == (1 << d)) begin
                    j = i - (1 << d);
                    t = ((rdy[i] > rdy[j]) ? rdy[i] : rdy[j]) + 1;
                    rdy[i] = t;
                    if (t > depth) depth = t;
                    if (t == lvl && i == pos) res = j;
                end
            end
        end
        return want_depth ? depth : res;
    endfunction

    function automatic int bk_depth(input int n);
        return bk_walk(n, 0, 0, 1'b1);
    endfunction

    function automatic int bk_src(input int n, input int lvl, input int pos);
        return bk_walk(n, lvl, pos, 1'b0);
    endfunction

endpackage

// File: rtl/maxpfx_node.sv
module maxpfx_node #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    // Signed compare: the sign-bit-only code is the smallest value, so it
    // behaves as minus infinity and never wins against a real word.
    always_comb y = ($signed(a) >= $signed(b)) ? a : b;
endmodule

// File: rtl/maxpfx_level.sv
module maxpfx_level
    import maxpfx_pkg::*;
#(
    parameter int N    = 16,
    parameter int W    = 16,
    parameter int LVL  = 1,
    parameter bit PIPE = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                v_in,
    input  logic [N-1:0][W-1:0] d_in,
    output logic                v_out,
    output logic [N-1:0][W-1:0] d_out
);
    localparam logic [W-1:0] NEG_INF = {1'b1, {(W-1){1'b0}}};

    logic [N-1:0][W-1:0] nxt;

    for (genvar p = 0; p < N; p++) begin : g_pos
        localparam int SRC = bk_src(N, LVL, p);
        if (SRC >= 0) begin : g_op
            maxpfx_node #(.W(W)) u_node (
                .a (d_in[p]),
                .b (d_in[SRC]),
                .y (nxt[p])
            );
        end else begin : g_pass
            assign nxt[p] = d_in[p];
        end
    end

    if (PIPE) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                v_out <= 1'b0;
                d_out <= {N{NEG_INF}};
            end else begin
                v_out <= v_in;
                if (v_in) d_out <= nxt;
            end
        end
    end else begin : g_comb
        assign v_out = v_in;
        assign d_out = nxt;
    end
endmodule

// File: rtl/maxpfx_bk.sv
module maxpfx_bk
    import maxpfx_pkg::*;
#(
    parameter int N    = 16,
    parameter int W    = 16,
    parameter bit PIPE = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [N*W-1:0] in_data,
    output logic           out_valid,
    output logic [N*W-1:0] out_data
);
    localparam int LVLS = bk_depth(N);

    logic [N-1:0][W-1:0] stg [LVLS+1];
    logic                vld [LVLS+1];

    assign stg[0] = in_data;
    assign vld[0] = in_valid;

    for (genvar l = 1; l <= LVLS; l++) begin : g_lvl
        maxpfx_level #(
            .N    (N),
            .W    (W),
            .LVL  (l),
            .PIPE (PIPE)
        ) u_level (
            .clk   (clk),
            .rst   (rst),
            .v_in  (vld[l-1]),
            .d_in  (stg[l-1]),
            .v_out (vld[l]),
            .d_out (stg[l])
        );
    end

    assign out_valid = vld[LVLS];
    assign out_data  = stg[LVLS];
endmodule

// File: rtl/maxpfx_chk.sv
module maxpfx_chk #(
    parameter int N    = 16,
    parameter int W    = 16,
    parameter bit PIPE = 1'b1
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [N*W-1:0] in_data,
    input logic           out_valid,
    input logic [N*W-1:0] out_data
);
    localparam int LAT = 2 * $clog2(N) - 2;
    localparam logic [W-1:0] NEG_INF = {1'b1, {(W-1){1'b0}}};

    function automatic logic [N*W-1:0] scan_ref(input logic [N*W-1:0] v);
        logic [N*W-1:0] r;
        logic [W-1:0]   run;
        run = v[W-1:0];
        for (int i = 0; i < N; i++) begin
            if ($signed(v[i*W +: W]) > $signed(run)) run = v[i*W +: W];
            r[i*W +: W] = run;
        end
        return r;
    endfunction

    function automatic bit nondecr(input logic [N*W-1:0] v);
        bit ok;
        ok = 1'b1;
        for (int i = 1; i < N; i++)
            if ($signed(v[i*W +: W]) < $signed(v[(i-1)*W +: W])) ok = 1'b0;
        return ok;
    endfunction

    logic           ref_valid;
    logic [N*W-1:0] ref_data;

    if (PIPE) begin : g_dly
        logic           dv [LAT];
        logic [N*W-1:0] dd [LAT];
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < LAT; i++) dv[i] <= 1'b0;
            end else begin
                dv[0] <= in_valid;
                for (int i = 1; i < LAT; i++) dv[i] <= dv[i-1];
            end
        end
        always_ff @(posedge clk) begin
            dd[0] <= in_data;
            for (int i = 1; i < LAT; i++) dd[i] <= dd[i-1];
        end
        assign ref_valid = dv[LAT-1];
        assign ref_data  = dd[LAT-1];

        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
            !out_valid |-> $stable(out_data)); // R7
    end else begin : g_direct
        assign ref_valid = in_valid;
        assign ref_data  = in_data;
    end

    AST_VALID_ALIGN: assert property (@(posedge clk) disable iff (rst)
        out_valid == ref_valid); // R5
    AST_PREFIX_MATCH: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data == scan_ref(ref_data)); // R1
    AST_WORD0_PASS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_data[W-1:0] == ref_data[W-1:0]); // R3
    AST_NONDECR: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> nondecr(out_data)); // R4
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == {N{NEG_INF}})); // R8
endmodule

bind maxpfx_bk maxpfx_chk #(.N(N), .W(W), .PIPE(PIPE)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/maxpfx_bk_tb_top.sv
`timescale 1ns/1ps
module maxpfx_bk_tb_top;
    localparam int N   = 16;
    localparam int W   = 16;
    localparam int LAT = 2 * $clog2(N) - 2;
    localparam logic [W-1:0] NEG_INF = {1'b1, {(W-1){1'b0}}};

    typedef struct {
        int             due;
        logic [N*W-1:0] exp;
        string          tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [N*W-1:0] in_data = '0;
    logic           out_valid;
    logic [N*W-1:0] out_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 1'b0;
    bit have_last = 1'b0;
    logic [N*W-1:0] last_out;
    exp_t q[$];
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #2 clk = ~clk;

    maxpfx_bk #(.N(N), .W(W), .PIPE(1'b1)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [N*W-1:0] expect_prefix(input logic [N*W-1:0] v);
        logic [N*W-1:0] r;
        logic signed [W-1:0] best;
        best = v[W-1:0];
        for (int i = 0; i < N; i++) begin
            if ($signed(v[i*W +: W]) > best) best = v[i*W +: W];
            r[i*W +: W] = best;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [N*W-1:0] got, input logic [N*W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic send(input logic [N*W-1:0] v, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v;
        e.due = cyc + LAT;
        e.exp = expect_prefix(v);
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = '1;
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    // Scoreboard monitor, sampling 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R5", "unexpected out_valid", out_data, '0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.due == cyc, "R5", "result cycle", out_data, e.exp);
                    check(out_data == e.exp, e.tag, "prefix vector", out_data, e.exp);
                end
                last_out  = out_data;
                have_last = 1'b1;
            end else begin
                if (q.size() > 0 && q[0].due <= cyc) begin
                    exp_t e;
                    e = q.pop_front();
                    check(1'b0, "R5", "missing out_valid", out_data, e.exp);
                end
                if (have_last)
                    check(out_data == last_out, "R7", "hold while idle", out_data, last_out);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL R5 watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N*W-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8", "out_valid after reset", {N*W{out_valid}}, '0);
        check(out_data == {N{NEG_INF}}, "R8", "out_data after reset", out_data, {N{NEG_INF}});

        // R1: ascending words
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(i * 100);
        send(v, "R1");
        idle(2);
        // R3: descending, every prefix equals word 0
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(1000 - i * 50);
        send(v, "R3");
        // R4: mixed signs, zig-zag
        for (int i = 0; i < N; i++) v[i*W +: W] = (i % 2 == 0) ? W'(-i * 7) : W'(i * 3 - 40);
        send(v, "R4");
        idle(LAT + 2);
        // R2: all minus infinity
        send({N{NEG_INF}}, "R2");
        // R2: minus infinity at word 0 and scattered between real words
        for (int i = 0; i < N; i++) v[i*W +: W] = (i % 3 == 0) ? NEG_INF : W'(-500 + i);
        send(v, "R2");
        // R9: extremes of the signed range
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(-1);
        v[5*W +: W]  = 16'h7FFF;
        v[9*W +: W]  = 16'h8001;
        send(v, "R9");
        idle(3);
        // R6: back-to-back stream of pseudo-random vectors
        for (int k = 0; k < 24; k++) begin
            for (int i = 0; i < N; i++) begin
                lfsr = step(lfsr);
                v[i*W +: W] = (lfsr[3:0] == 4'd0) ? NEG_INF : lfsr[W-1:0];
            end
            send(v, "R6");
        end
        idle(LAT + 6);
        check(q.size() == 0, "R5", "outstanding results", N*W'(q.size()), '0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule